// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block lets an on-chip requester read and write an external asynchronous static RAM of 262,144 sixteen-bit words. The requester offers one access at a time over a valid/ready handshake. Each access carries an 18-bit word address, a write flag, 16 bits of write data and two active-high byte-lane enables. The controller registers the access and drives the memory's active-low chip enable, write enable, output enable and the two byte-lane strobes. A parameter sets how many clock cycles each strobe lasts.

The shared 16-bit data bus is driven by the controller only while a write is under way. At all other times it is released, so the memory can drive it. Reads return a 16-bit word together with a one-cycle response pulse. Any byte lane that was not requested comes back as zero. A request with no lanes enabled is finished in the cycle it is accepted, and the memory is never selected for it.

Back-pressure rules: `req_ready` is high only while the controller is idle. A requester that raises `req_valid` must hold the address, flag, data and enables steady until it sees `req_ready` high at a clock edge. The response side has no back-pressure. `rsp_valid` is high for one cycle, and `rsp_rdata` holds its value until the next response.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst_n` is low, `sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_lb_n` and `sram_ub_n` are all high, `rsp_valid` is low, `req_ready` is high after the first reset edge, and the data bus is released.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the edge that accepts a request with at least one lane enabled until the controller has returned to idle.
- R3: A read with at least one lane enabled holds `sram_ce_n` and `sram_oe_n` low and `sram_we_n` high for exactly ACCESS_CYC cycles, starting in the cycle after acceptance. Address and lane strobes stay constant throughout.
- R4: Read data is sampled from the bus at the edge that ends the last strobe cycle. `rsp_valid` is high for the single following cycle, and `rsp_rdata` keeps the word until the next response.
- R5: `req_be[0]` selects bits 7:0 and drives `sram_lb_n` low during the strobe. `req_be[1]` selects bits 15:8 and drives `sram_ub_n` low. A lane that was not requested returns zero in `rsp_rdata`.
- R6: A write with at least one lane enabled holds `sram_ce_n` and `sram_we_n` low and `sram_oe_n` high for exactly ACCESS_CYC cycles, starting in the cycle after acceptance. The registered write word is driven on `sram_dq` throughout.
- R7: After a write strobe there is one hold cycle. In that cycle `sram_we_n` is high while `sram_ce_n` stays low, and the address and write data are unchanged. Only after it does the controller go idle.
- R8: The controller drives `sram_dq` only during write strobe and hold cycles. It never drives the bus while `sram_oe_n` is low.
- R9: A request whose lane enables are both zero is accepted without any strobe, and `req_ready` stays high. A read of this kind yields `rsp_valid` with all-zero data in the next cycle. A write of this kind yields no response.
- R10: A new request held ready on the bus is accepted in the first cycle the controller is idle again. For reads that is the cycle carrying `rsp_valid`; for writes it is the cycle after the hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 18 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Active-high byte-lane enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle pulse marking returned read data |
| rsp_rdata | output | 16 | Read word, unrequested lanes zero |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_lb_n | output | 1 | Low byte strobe, active low |
| sram_ub_n | output | 1 | High byte strobe, active low |
| sram_addr | output | 18 | Memory address bus |
| sram_dq | inout | 16 | Shared data bus |

## Verification
The hardest case to reach from the ports is a sample taken too early. A memory that answers at once would hide a controller that reads the bus before the access time has passed. The bench's memory model therefore puts junk on every enabled lane until two full cycles of steady read strobe have gone by. It also puts a different junk byte on lanes that were not requested, so both an early sample and a missing zero-fill show up in the returned word. Back-to-back traffic is made by keeping `req_valid` high across transactions. This includes runs of zero-lane requests, which must each be taken in consecutive idle cycles.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // Controller phase; the strobes are decoded from it.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int LANES      = 2,
  parameter int ACCESS_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  output logic             req_ready,
  output phase_e           phase,
  output logic             accept,
  output logic             sample,
  output logic             zero_rd,
  output logic             rsp_valid
);

  localparam int CNT_W = (ACCESS_CYC > 1) ? $clog2(ACCESS_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ACCESS_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             last_cyc;
  logic             any_lane;

  assign any_lane  = |req_be;
  assign last_cyc  = (cnt_q == LAST_CNT);
  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid & req_ready;
  assign sample    = (phase == PH_READ) & last_cyc;
  assign zero_rd   = accept & ~any_lane & ~req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt_q     <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          cnt_q <= '0;
          if (accept) begin
            if (any_lane) begin
              phase <= req_write ? PH_WRITE : PH_READ;
            end else if (!req_write) begin
              rsp_valid <= 1'b1;
            end
          end
        end
        PH_READ: begin
          if (last_cyc) begin
            phase     <= PH_IDLE;
            rsp_valid <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_WRITE: begin
          if (last_cyc) begin
            phase <= PH_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HOLD: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // A real access closes the handshake on the next cycle.
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (|req_be)) |=> !req_ready);

  // An empty request leaves the controller idle.
  assert_empty_stays_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(|req_be)) |=> (req_ready && phase == PH_IDLE));

  // The last read cycle is followed by the response in an idle cycle.
  assert_rsp_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ && last_cyc) |=> (rsp_valid && req_ready));

  // A write strobe always ends in the hold phase.
  assert_write_then_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WRITE && last_cyc) |=> (phase == PH_HOLD));

endmodule

// File: rtl/sram_ctrl_lane.sv
module sram_ctrl_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              en_i,
  input  logic [LANE_W-1:0] wr_i,
  input  logic              capture_i,
  input  logic              take_bus_i,
  input  logic [LANE_W-1:0] bus_i,
  output logic              en_o,
  output logic [LANE_W-1:0] wr_o,
  output logic [LANE_W-1:0] rd_o
);

  // Request side: enable and write byte held for the whole access.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o <= 1'b0;
      wr_o <= '0;
    end else if (load_i) begin
      en_o <= en_i;
      wr_o <= wr_i;
    end
  end

  // Response side: bus byte for an enabled lane, zero otherwise.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_o <= '0;
    end else if (capture_i) begin
      rd_o <= (take_bus_i && en_o) ? bus_i : '0;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int ACCESS_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [ADDR_W-1:0] sram_addr,
  inout  wire  [DATA_W-1:0] sram_dq
);

  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  phase_e             phase;
  logic               accept;
  logic               sample;
  logic               zero_rd;
  logic               active;
  logic               bus_drive;
  logic [LANES-1:0]   lane_en;
  logic [LANES-1:0]   lane_n;
  logic [DATA_W-1:0]  wr_word;
  logic [ADDR_W-1:0]  addr_q;

  sram_ctrl_seq #(
    .LANES      (LANES),
    .ACCESS_CYC (ACCESS_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_be    (req_be),
    .req_ready (req_ready),
    .phase     (phase),
    .accept    (accept),
    .sample    (sample),
    .zero_rd   (zero_rd),
    .rsp_valid (rsp_valid)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_ctrl_lane #(.LANE_W(LANE_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .en_i       (req_be[g]),
      .wr_i       (req_wdata[g*LANE_W +: LANE_W]),
      .capture_i  (sample | zero_rd),
      .take_bus_i (sample),
      .bus_i      (sram_dq[g*LANE_W +: LANE_W]),
      .en_o       (lane_en[g]),
      .wr_o       (wr_word[g*LANE_W +: LANE_W]),
      .rd_o       (rsp_rdata[g*LANE_W +: LANE_W])
    );
    assign lane_n[g] = ~(active & lane_en[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
    end
  end

  assign active    = (phase != PH_IDLE);
  assign bus_drive = (phase == PH_WRITE) || (phase == PH_HOLD);
  assign sram_ce_n = ~active;
  assign sram_we_n = ~(phase == PH_WRITE);
  assign sram_oe_n = ~(phase == PH_READ);
  assign sram_lb_n = lane_n[0];
  assign sram_ub_n = lane_n[LANES-1];
  assign sram_addr = addr_q;
  assign sram_dq   = bus_drive ? wr_word : {DATA_W{1'bz}};

  // The bus is never driven against the memory's outputs.
  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (sram_oe_n && !sram_ce_n));

  // Address and lane strobes hold across a continuing access.
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && !$past(sram_ce_n)) |->
      ($stable(sram_addr) && $stable(sram_lb_n) && $stable(sram_ub_n)));

  // A write strobe only occurs with the chip selected and outputs off.
  assert_write_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n && bus_drive));

  // Rising write enable leaves chip enable and data in place one cycle.
  assert_hold_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (!sram_ce_n && bus_drive && $stable(sram_addr)));

  // A selected chip always has at least one lane strobed.
  assert_lane_when_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !(sram_lb_n && sram_ub_n));

endmodule

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_ctrl_tb_top;

  localparam int ACC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [17:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;
  logic [17:0] sram_addr;
  wire  [15:0] sram_dq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sram_ctrl #(.ACCESS_CYC(ACC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
    .sram_addr(sram_addr), .sram_dq(sram_dq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [15:0] w, input logic [1:0] be);
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  // ---------------- behavioural memory ----------------
  logic [15:0] mem_arr [logic [17:0]];
  int          rd_age = 0;
  logic        rd_active;
  logic [15:0] mem_q;

  assign rd_active = !sram_ce_n && !sram_oe_n && sram_we_n && !(sram_lb_n && sram_ub_n);

  always_comb begin
    logic [15:0] w;
    logic        ok;
    w  = mem_arr.exists(sram_addr) ? mem_arr[sram_addr] : 16'h0000;
    ok = (rd_age >= 2);
    mem_q[7:0]  = !sram_lb_n ? (ok ? w[7:0]  : 8'hDE) : 8'h5A;
    mem_q[15:8] = !sram_ub_n ? (ok ? w[15:8] : 8'hAD) : 8'hC3;
  end

  assign sram_dq = rd_active ? mem_q : 16'bz;

  always @(posedge clk) begin
    rd_age <= rd_active ? rd_age + 1 : 0;
    if (rst_n && !sram_ce_n && !sram_we_n) begin
      logic [15:0] w;
      w = mem_arr.exists(sram_addr) ? mem_arr[sram_addr] : 16'h0000;
      if (!sram_lb_n) w[7:0]  = sram_dq[7:0];
      if (!sram_ub_n) w[15:8] = sram_dq[15:8];
      mem_arr[sram_addr] = w;
    end
  end

  // ---------------- cycle reference model ----------------
  logic [15:0] shadow [logic [17:0]];
  int          m_left = 0;
  int          m_hold = 0;
  bit          m_write = 1'b0;
  logic [17:0] m_addr = '0;
  logic [1:0]  m_be = '0;
  logic [15:0] m_wdata = '0;
  bit          e_rsp = 1'b0;
  bit          e_zero = 1'b0;
  logic [15:0] e_rdata = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0;
      m_hold = 0;
      e_rsp  = 1'b0;
    end else begin
      e_rsp = 1'b0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          if (m_write) m_hold = 1;
          else begin
            e_rsp   = 1'b1;
            e_zero  = 1'b0;
            e_rdata = lane_mask(shadow.exists(m_addr) ? shadow[m_addr] : 16'h0, m_be);
          end
        end
      end else if (m_hold > 0) begin
        m_hold--;
      end else if (req_valid) begin
        if (req_be == 2'b00) begin
          if (!req_write) begin
            e_rsp   = 1'b1;
            e_zero  = 1'b1;
            e_rdata = 16'h0000;
          end
        end else begin
          m_left  = ACC;
          m_write = req_write;
          m_addr  = req_addr;
          m_be    = req_be;
          m_wdata = req_wdata;
          if (req_write) begin
            logic [15:0] w;
            w = shadow.exists(req_addr) ? shadow[req_addr] : 16'h0;
            if (req_be[0]) w[7:0]  = req_wdata[7:0];
            if (req_be[1]) w[15:8] = req_wdata[15:8];
            shadow[req_addr] = w;
          end
        end
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit busy, wr_ph, rd_ph;
      busy  = (m_left > 0) || (m_hold > 0);
      wr_ph = (m_left > 0) && m_write;
      rd_ph = (m_left > 0) && !m_write;
      chk(req_ready === !busy, "R2 R10 req_ready", req_ready, !busy);
      chk(sram_ce_n === !busy, "R3 R6 sram_ce_n", sram_ce_n, !busy);
      chk(sram_we_n === !wr_ph, (m_hold > 0) ? "R7 sram_we_n" : "R6 sram_we_n",
          sram_we_n, !wr_ph);
      chk(sram_oe_n === !rd_ph, "R3 sram_oe_n", sram_oe_n, !rd_ph);
      chk(sram_lb_n === !(busy && m_be[0]), "R5 sram_lb_n", sram_lb_n, !(busy && m_be[0]));
      chk(sram_ub_n === !(busy && m_be[1]), "R5 sram_ub_n", sram_ub_n, !(busy && m_be[1]));
      chk(rsp_valid === e_rsp, "R4 rsp_valid", rsp_valid, e_rsp);
      if (busy) chk(sram_addr === m_addr, "R3 sram_addr", sram_addr, m_addr);
      if (wr_ph || m_hold > 0)
        chk(sram_dq === m_wdata, "R8 write data on bus", sram_dq, m_wdata);
      if (e_rsp)
        chk(rsp_rdata === e_rdata, e_zero ? "R9 empty read data" : "R5 read data",
            rsp_rdata, e_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic [17:0] a, input bit w, input logic [15:0] d,
                       input logic [1:0] be);
    req_valid = 1'b1;
    req_addr  = a;
    req_write = w;
    req_wdata = d;
    req_be    = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic gap(input int n);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: strobes inactive and no response while in reset.
    chk(sram_ce_n === 1'b1, "R1 ce_n in reset", sram_ce_n, 1);
    chk(sram_we_n === 1'b1, "R1 we_n in reset", sram_we_n, 1);
    chk(sram_oe_n === 1'b1, "R1 oe_n in reset", sram_oe_n, 1);
    chk({sram_lb_n, sram_ub_n} === 2'b11, "R1 lanes in reset", {sram_lb_n, sram_ub_n}, 2'b11);
    chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
    chk(req_ready === 1'b1, "R1 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // Full-word writes and reads, address extremes.
    issue(18'h00000, 1, 16'h1234, 2'b11); gap(1);
    issue(18'h3FFFF, 1, 16'hBEEF, 2'b11); gap(1);
    issue(18'h00000, 0, 16'h0, 2'b11);    gap(2);
    issue(18'h3FFFF, 0, 16'h0, 2'b11);    gap(2);
    // R5: single-lane writes and reads.
    issue(18'h00100, 1, 16'hAAAA, 2'b11); gap(0);
    issue(18'h00100, 1, 16'h55CC, 2'b01); gap(0);
    issue(18'h00100, 1, 16'h77EE, 2'b10); gap(0);
    issue(18'h00100, 0, 16'h0, 2'b01);    gap(0);
    issue(18'h00100, 0, 16'h0, 2'b10);    gap(0);
    issue(18'h00100, 0, 16'h0, 2'b11);    gap(2);
    // R9: empty requests, back to back.
    issue(18'h00100, 0, 16'h0, 2'b00);
    issue(18'h00100, 1, 16'hFFFF, 2'b00);
    issue(18'h00100, 0, 16'h0, 2'b00);
    issue(18'h00100, 0, 16'h0, 2'b11);    gap(3);
    // Mixed traffic, R10 back to back where gap is zero.
    for (int i = 0; i < 400; i++) begin
      logic [17:0] a;
      a = (i % 7 == 0) ? 18'h3FFFF : 18'($urandom_range(0, 15));
      issue(a, 1'($urandom_range(0, 1)), 16'($urandom()), 2'($urandom_range(0, 3)));
      gap(($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0);
    end
    gap(8);
    finish_run();
  end

endmodule